// File: doc/BRIEF.md
# DRAM Read Burst Return Scheduler

This block sits on the controller side of a DRAM read path. It watches each read command as the command is issued and predicts, cycle by cycle, when the matching data burst comes back on the bus. For every controller clock cycle it gives the data path the strobes it needs: a capture enable, the column index of the two beats that arrive in that cycle (one on each clock edge), an end-of-burst marker, the strobe preamble and postamble windows, and a bus-released indication. For a read that asks for auto-precharge it also marks the cycle in which the row can be treated as closed.

The return delay is the sum of two separately programmed latencies, the CAS latency and the additive latency. Both are loaded through a mode-register write port that accepts only legal pairs. A read is either a full 8-beat burst (4 clock cycles of data) or a chopped 4-beat burst (2 clock cycles). Reads must be at least 4 clocks apart. At that spacing full bursts join without a gap, and chopped bursts leave a 2-cycle hole. A read issued too soon is rejected and flagged, and the burst already in flight is left whole.

Top module: `rd_return_sched`

## Requirements
- R1: After reset the capture enable, end-of-burst, row-closed, preamble, postamble and violation outputs are all low and the bus-released output is high. The latencies reset to CL=5 and AL=0.
- R2: The first data cycle of an accepted read comes exactly AL+CL cycles after the cycle in which `rd_cmd` is high. With CL=8 and AL=0 this is 8 cycles.
- R3: A mode-register write loads CL and AL only if 5 <= CL <= 14 and AL < CL. Otherwise both values keep their old setting. A read issued in the same cycle as a mode-register write uses the old values.
- R4: A full read (`rd_chop`=0) gives 4 consecutive data cycles. In data cycle j (0..3) the beat indices are lo=(col+2j) mod 8 and hi=(col+2j+1) mod 8.
- R5: A chopped read (`rd_chop`=1) gives 2 consecutive data cycles. In data cycle j (0..1) the beat indices are lo=(col mod 4+2j) mod 4 and hi=(col mod 4+2j+1) mod 4, so no index exceeds 3.
- R6: Two full reads issued exactly 4 cycles apart give 8 unbroken data cycles. No postamble is flagged between the two bursts.
- R7: Two chopped reads issued 4 cycles apart leave a 2-cycle gap. Bus-released is high in the first gap cycle and the preamble is high in the second.
- R8: A read issued 1 to 3 cycles after the last accepted read is dropped and produces no data. `cmd_viol` pulses high in the following cycle. The spacing is still measured from the last accepted read.
- R9: `burst_end` is high on the last data cycle of every burst. `row_closed` is high in that same cycle only if the read had `rd_ap`=1.
- R10: `dqs_pre` is high in a non-data cycle that is followed by a data cycle. `dqs_post` is high on a data cycle that is followed by a non-data cycle. `bus_hiz` is high when the cycle carries neither data nor the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_we | input | 1 | Mode-register write strobe |
| mrs_cl | input | 4 | CAS latency to load |
| mrs_al | input | 4 | Additive latency to load |
| rd_cmd | input | 1 | Read command issued this cycle |
| rd_chop | input | 1 | 1 = chopped 4-beat burst, 0 = full 8-beat burst |
| rd_ap | input | 1 | Auto-precharge requested with the read |
| rd_col | input | 3 | Starting column (low bits) of the burst |
| cap_en | output | 1 | Read data is on the bus this cycle |
| beat_lo_idx | output | 3 | Index of the beat on the rising edge |
| beat_hi_idx | output | 3 | Index of the beat on the falling edge |
| burst_end | output | 1 | Last data cycle of a burst |
| row_closed | output | 1 | Auto-precharge burst finished; row may be treated as closed |
| dqs_pre | output | 1 | Strobe preamble window |
| dqs_post | output | 1 | Strobe postamble window |
| bus_hiz | output | 1 | Data bus released (high impedance) |
| cmd_viol | output | 1 | Read spacing violation, one cycle after the offending read |

## Verification
Single reads are tried at several latency pairs, including the smallest (5+0) and the largest (14+13). This separates a correct AL+CL sum from an off-by-one delay, from a value that has wrapped, and from a delay that uses only one of the two latencies. Full and chopped bursts are started at odd and even columns, which shows whether the index wraps inside 8 or inside 4. Reads spaced exactly 4 apart are issued full-full, chopped-chopped, full-chopped and chopped-full, to tell a seamless merge from a correct gap and to place the preamble and postamble around each join. Reads spaced 2 and 3 cycles apart, illegal latency writes, and a write in the same cycle as a read show that a rejected command changes neither the in-flight burst nor the timing.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int TCCD      = 4;   // minimum read-to-read spacing in clocks
    localparam int BURST_CYC = 4;   // clock cycles of a full burst
    localparam int BEAT_W    = 3;   // beat index width (8 beats)

    typedef struct packed {
        logic              vld;
        logic [BEAT_W-1:0] lo;
        logic [BEAT_W-1:0] hi;
        logic              last;
        logic              ap;
    } slot_t;
endpackage

// File: rtl/rrs_lat_cfg.sv
module rrs_lat_cfg #(
    parameter int CL_MIN = 5,
    parameter int CL_MAX = 14,
    parameter int CL_RST = 5,
    parameter int AL_RST = 0,
    parameter int LAT_W  = 4,
    parameter int RL_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_we,
    input  logic [LAT_W-1:0] mrs_cl,
    input  logic [LAT_W-1:0] mrs_al,
    output logic [RL_W-1:0]  rl
);
    typedef struct packed {
        logic [LAT_W-1:0] cl;
        logic [LAT_W-1:0] al;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic legal;

    always_comb begin
        cfg_d = cfg_q;
        legal = (mrs_cl >= LAT_W'(CL_MIN)) && (mrs_cl <= LAT_W'(CL_MAX)) && (mrs_al < mrs_cl);
        if (mrs_we && legal) begin
            cfg_d.cl = mrs_cl;
            cfg_d.al = mrs_al;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.cl <= LAT_W'(CL_RST);
            cfg_q.al <= LAT_W'(AL_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rl = RL_W'(cfg_q.cl) + RL_W'(cfg_q.al);

    // R3
    lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.cl >= LAT_W'(CL_MIN)) && (cfg_q.cl <= LAT_W'(CL_MAX)) && (cfg_q.al < cfg_q.cl));

    // R3
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_we |=> $stable(cfg_q));
endmodule

// File: rtl/rrs_ccd_guard.sv
module rrs_ccd_guard #(
    parameter int SPACING = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cmd,
    output logic accept,
    output logic viol
);
    localparam int CNT_W = $clog2(SPACING + 1);

    typedef struct packed {
        logic [CNT_W-1:0] gap;
        logic             viol;
    } grd_t;

    grd_t grd_d, grd_q;

    always_comb begin
        grd_d  = grd_q;
        accept = rd_cmd && (grd_q.gap >= CNT_W'(SPACING));
        if (accept)
            grd_d.gap = CNT_W'(1);
        else if (grd_q.gap < CNT_W'(SPACING))
            grd_d.gap = grd_q.gap + CNT_W'(1);
        grd_d.viol = rd_cmd && !accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grd_q.gap  <= CNT_W'(SPACING);
            grd_q.viol <= 1'b0;
        end else begin
            grd_q <= grd_d;
        end
    end

    assign viol = grd_q.viol;

    // R8
    accept_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept ##1 !accept ##1 !accept);
endmodule

// File: rtl/rrs_timeline.sv
module rrs_timeline
    import rrs_pkg::*;
#(
    parameter int DEPTH = 30,
    parameter int RL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched,
    input  logic              chop,
    input  logic              ap,
    input  logic [BEAT_W-1:0] col,
    input  logic [RL_W-1:0]   rl,
    output slot_t             now_slot,
    output logic              next_vld
);
    typedef struct packed {
        slot_t [DEPTH-1:0] sl;
    } tl_t;

    tl_t tl_d, tl_q;
    int  ncyc;

    function automatic slot_t make_slot(input logic c, input logic a,
                                        input logic [BEAT_W-1:0] cs, input int j, input int n);
        slot_t s;
        s.vld = 1'b1;
        if (c) begin
            s.lo = {1'b0, cs[1:0] + 2'(2 * j)};
            s.hi = {1'b0, cs[1:0] + 2'(2 * j + 1)};
        end else begin
            s.lo = cs + BEAT_W'(2 * j);
            s.hi = cs + BEAT_W'(2 * j + 1);
        end
        s.last = (j == n - 1);
        s.ap   = a && (j == n - 1);
        return s;
    endfunction

    always_comb begin
        ncyc     = chop ? (BURST_CYC / 2) : BURST_CYC;
        // slot k describes the cycle k clocks after the current one
        tl_d.sl  = tl_q.sl >> $bits(slot_t);
        for (int k = 0; k < DEPTH; k++) begin
            for (int j = 0; j < BURST_CYC; j++) begin
                if (sched && (j < ncyc) && (k == int'(rl) + j - 1))
                    tl_d.sl[k] = make_slot(chop, ap, col, j, ncyc);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tl_q <= '0;
        else
            tl_q <= tl_d;
    end

    assign now_slot = tl_q.sl[0];
    assign next_vld = tl_q.sl[1].vld;

    // R4
    no_truncate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_slot.vld && !now_slot.last) |=> now_slot.vld);

    // R9
    close_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_slot.ap |-> (now_slot.vld && now_slot.last));
endmodule

// File: rtl/rd_return_sched.sv
module rd_return_sched
    import rrs_pkg::*;
#(
    parameter int CL_MIN = 5,
    parameter int CL_MAX = 14,
    parameter int CL_RST = 5,
    parameter int AL_RST = 0,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_we,
    input  logic [LAT_W-1:0]  mrs_cl,
    input  logic [LAT_W-1:0]  mrs_al,
    input  logic              rd_cmd,
    input  logic              rd_chop,
    input  logic              rd_ap,
    input  logic [BEAT_W-1:0] rd_col,
    output logic              cap_en,
    output logic [BEAT_W-1:0] beat_lo_idx,
    output logic [BEAT_W-1:0] beat_hi_idx,
    output logic              burst_end,
    output logic              row_closed,
    output logic              dqs_pre,
    output logic              dqs_post,
    output logic              bus_hiz,
    output logic              cmd_viol
);
    localparam int RL_MAX = CL_MAX + CL_MAX - 1;
    localparam int RL_W   = $clog2(RL_MAX + 1);
    localparam int DEPTH  = RL_MAX + BURST_CYC - 1;

    logic [RL_W-1:0] rl;
    logic            accept;
    slot_t           now_slot;
    logic            next_vld;

    rrs_lat_cfg #(
        .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .CL_RST(CL_RST),
        .AL_RST(AL_RST), .LAT_W(LAT_W), .RL_W(RL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .mrs_we(mrs_we),
        .mrs_cl(mrs_cl), .mrs_al(mrs_al), .rl(rl)
    );

    rrs_ccd_guard #(.SPACING(TCCD)) u_guard (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd),
        .accept(accept), .viol(cmd_viol)
    );

    rrs_timeline #(.DEPTH(DEPTH), .RL_W(RL_W)) u_tl (
        .clk(clk), .rst_n(rst_n), .sched(accept), .chop(rd_chop),
        .ap(rd_ap), .col(rd_col), .rl(rl),
        .now_slot(now_slot), .next_vld(next_vld)
    );

    always_comb begin
        cap_en      = now_slot.vld;
        beat_lo_idx = now_slot.lo;
        beat_hi_idx = now_slot.hi;
        burst_end   = now_slot.vld && now_slot.last;
        row_closed  = now_slot.ap;
        dqs_pre     = !now_slot.vld && next_vld;
        dqs_post    = now_slot.vld && now_slot.last && !next_vld;
        bus_hiz     = !now_slot.vld && !dqs_pre;
    end

    // R10
    pre_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pre |=> cap_en);

    // R10
    post_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_post |=> !cap_en);

    // R8
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_viol |-> $past(rd_cmd));
endmodule

// File: tb/rd_return_sched_tb.sv
module rd_return_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrs_we = 1'b0;
    logic [3:0] mrs_cl = '0;
    logic [3:0] mrs_al = '0;
    logic       rd_cmd = 1'b0;
    logic       rd_chop = 1'b0;
    logic       rd_ap = 1'b0;
    logic [2:0] rd_col = '0;
    logic       cap_en, burst_end, row_closed, dqs_pre, dqs_post, bus_hiz, cmd_viol;
    logic [2:0] beat_lo_idx, beat_hi_idx;

    always #5 clk = ~clk;

    rd_return_sched u_dut (
        .clk(clk), .rst_n(rst_n), .mrs_we(mrs_we), .mrs_cl(mrs_cl), .mrs_al(mrs_al),
        .rd_cmd(rd_cmd), .rd_chop(rd_chop), .rd_ap(rd_ap), .rd_col(rd_col),
        .cap_en(cap_en), .beat_lo_idx(beat_lo_idx), .beat_hi_idx(beat_hi_idx),
        .burst_end(burst_end), .row_closed(row_closed), .dqs_pre(dqs_pre),
        .dqs_post(dqs_post), .bus_hiz(bus_hiz), .cmd_viol(cmd_viol)
    );

    typedef struct {
        int at;
        int lo;
        int hi;
        bit last;
        bit ap;
        bit chop;
    } exp_t;

    exp_t sbq[$];
    bit   viol_exp[int];
    int   cyc = 0;
    int   vectors = 0;
    int   miscompares = 0;
    int   tb_cl = 5;
    int   tb_al = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    // monitor: pops the scoreboard in the cycle each item is due
    always @(negedge clk) begin : mon
        bit   now_d, nxt_d;
        exp_t e;
        string tag;
        if (rst_n && !done) begin
            now_d = (sbq.size() > 0) && (sbq[0].at == cyc);
            if (now_d)
                nxt_d = (sbq.size() > 1) && (sbq[1].at == cyc + 1);
            else
                nxt_d = (sbq.size() > 0) && (sbq[0].at == cyc + 1);
            chk("R2", "cap_en timing", int'(cap_en), int'(now_d));
            if (now_d) begin
                e = sbq.pop_front();
                tag = e.chop ? "R5" : "R4";
                chk(tag, "beat_lo_idx", int'(beat_lo_idx), e.lo);
                chk(tag, "beat_hi_idx", int'(beat_hi_idx), e.hi);
                chk("R9", "burst_end", int'(burst_end), int'(e.last));
                chk("R9", "row_closed", int'(row_closed), int'(e.ap));
                chk("R10", "dqs_post", int'(dqs_post), int'(e.last && !nxt_d));
            end else begin
                chk("R10", "dqs_post idle", int'(dqs_post), 0);
            end
            chk("R10", "dqs_pre", int'(dqs_pre), int'(!now_d && nxt_d));
            chk("R10", "bus_hiz", int'(bus_hiz), int'(!now_d && !nxt_d));
            chk("R8", "cmd_viol", int'(cmd_viol), int'(viol_exp.exists(cyc)));
        end
    end

    task automatic push_read(input bit chop, input bit ap, input int col, input int rl);
        int n;
        n = chop ? 2 : 4;
        for (int j = 0; j < n; j++) begin
            exp_t e;
            e.at   = cyc + rl + j;
            e.chop = chop;
            e.lo   = chop ? (((col % 4) + 2 * j) % 4) : ((col + 2 * j) % 8);
            e.hi   = chop ? (((col % 4) + 2 * j + 1) % 4) : ((col + 2 * j + 1) % 8);
            e.last = (j == n - 1);
            e.ap   = ap && (j == n - 1);
            sbq.push_back(e);
        end
    endtask

    task automatic rd(input bit chop, input bit ap, input int col, input bit ok);
        rd_cmd  = 1'b1;
        rd_chop = chop;
        rd_ap   = ap;
        rd_col  = 3'(col);
        if (ok) push_read(chop, ap, col, tb_cl + tb_al);
        else viol_exp[cyc + 1] = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        rd_ap  = 1'b0;
    endtask

    function automatic bit legal(input int cl, input int al);
        return (cl >= 5) && (cl <= 14) && (al < cl);
    endfunction

    task automatic mrs(input int cl, input int al);
        mrs_we = 1'b1;
        mrs_cl = 4'(cl);
        mrs_al = 4'(al);
        @(negedge clk);
        mrs_we = 1'b0;
        if (legal(cl, al)) begin
            tb_cl = cl;
            tb_al = al;
        end
    endtask

    task automatic mrs_rd(input int cl, input int al, input int col);
        mrs_we = 1'b1;
        mrs_cl = 4'(cl);
        mrs_al = 4'(al);
        rd_cmd = 1'b1;
        rd_chop = 1'b0;
        rd_col = 3'(col);
        push_read(1'b0, 1'b0, col, tb_cl + tb_al);
        @(negedge clk);
        mrs_we = 1'b0;
        rd_cmd = 1'b0;
        if (legal(cl, al)) begin
            tb_cl = cl;
            tb_al = al;
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic first_at(input int c0, input int rl, input string tag);
        wait_cyc(c0 + rl - 1);
        chk(tag, "no data one cycle before RL", int'(cap_en), 0);
        @(negedge clk);
        chk(tag, "data at RL", int'(cap_en), 1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cap_en", int'(cap_en), 0);
        chk("R1", "bus_hiz", int'(bus_hiz), 1);
        chk("R1", "cmd_viol", int'(cmd_viol), 0);
        chk("R1", "dqs_pre", int'(dqs_pre), 0);
        chk("R1", "row_closed", int'(row_closed), 0);

        // R1 reset latency 5+0
        c0 = cyc; rd(1'b0, 1'b0, 2, 1'b1);
        first_at(c0, 5, "R1");
        drain();

        // R2 CL=8 AL=0
        mrs(8, 0);
        c0 = cyc; rd(1'b0, 1'b0, 0, 1'b1);
        first_at(c0, 8, "R2");
        drain();
        // R5 chopped, col 6, auto-precharge
        rd(1'b1, 1'b1, 6, 1'b1);
        drain();

        // R6 seamless full bursts, RL 9
        mrs(6, 3);
        c0 = cyc; rd(1'b0, 1'b0, 3, 1'b1);
        wait_cyc(c0 + 4); rd(1'b0, 1'b1, 5, 1'b1);
        wait_cyc(c0 + 9);
        for (int i = 0; i < 8; i++) begin
            chk("R6", "continuous cap_en", int'(cap_en), 1);
            if (i < 7) chk("R6", "no postamble inside", int'(dqs_post), 0);
            @(negedge clk);
        end
        drain();

        // R7 chopped bursts leave a gap
        c0 = cyc; rd(1'b1, 1'b0, 1, 1'b1);
        wait_cyc(c0 + 4); rd(1'b1, 1'b1, 7, 1'b1);
        wait_cyc(c0 + 11);
        chk("R7", "bus_hiz in gap", int'(bus_hiz), 1);
        @(negedge clk);
        chk("R7", "preamble in gap", int'(dqs_pre), 1);
        @(negedge clk);
        chk("R7", "second burst", int'(cap_en), 1);
        drain();

        // R8 early reads dropped
        c0 = cyc; rd(1'b0, 1'b1, 4, 1'b1);
        wait_cyc(c0 + 2); rd(1'b0, 1'b0, 0, 1'b0);
        rd(1'b1, 1'b0, 0, 1'b0);
        wait_cyc(c0 + 4); rd(1'b1, 1'b0, 2, 1'b1);
        drain();

        // R3 illegal writes keep 6+3
        mrs(15, 0);
        mrs(7, 7);
        c0 = cyc; rd(1'b0, 1'b0, 1, 1'b1);
        first_at(c0, 9, "R3");
        drain();
        // R3 write with read in the same cycle: read uses the old sum
        c0 = cyc; mrs_rd(10, 2, 6);
        first_at(c0, 9, "R3");
        drain();
        c0 = cyc; rd(1'b1, 1'b0, 3, 1'b1);
        first_at(c0, 12, "R3");
        drain();

        // largest latency 14+13
        mrs(14, 13);
        c0 = cyc; rd(1'b0, 1'b1, 7, 1'b1);
        first_at(c0, 27, "R2");
        drain();

        // smallest latency, mixed joins
        mrs(5, 0);
        c0 = cyc; rd(1'b0, 1'b0, 6, 1'b1);
        wait_cyc(c0 + 4); rd(1'b1, 1'b1, 5, 1'b1);
        wait_cyc(c0 + 8); rd(1'b0, 1'b0, 1, 1'b1);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule